// File: doc/BRIEF.md
# One-Time-Programmable Fuse Sequencer

This block is a register-mapped controller for a one-time-programmable fuse array. The array is modelled inside the block as banks of eight 32-bit words. Software first sets the phase lengths in a timing register. It then places a fuse address, and for programming an unlock key, in the control register. An access starts with a write to the read-control register (sense) or to the program-data register (program). While the access runs, a busy flag stays high. When busy drops, sensed data can be read from a read-data register.

Each access runs as a relax phase, a strobe phase and a second relax phase. The length of every phase comes from the timing register, counted in clock cycles. Programming can only set bits, because the data word is ORed into the addressed fuse word. Once a program access completes, the unlock key clears itself. Any access that is refused sets a sticky error flag and does not start a cycle. The flag stays set until software clears it through the clear alias of the control register.

Top module: `fuse_seq_top`

## Requirements
- R1: After reset, every readable register reads 0 (busy, error, unlock field, address, timing, read data, program data), fuseStrobe is low and all fuse words are 0.
- R2: Word offsets are 0 control, 1 control-set, 2 control-clear, 3 timing, 4 read-control, 5 read-data, 6 program-data. The control register holds the unlock field in bits 31:16, error in bit 9, busy in bit 8 and the fuse address in bits 6:0; all other bits read 0. A plain write loads bits 31:16 and 6:0. The set alias ORs into those fields and the clear alias clears the bits written as 1. Bits 8 and 9 cannot be written by the plain or set alias. Offsets 1 and 2 read back the control register.
- R3: The timing register holds the strobe-read count in bits 21:16, the relax count in bits 15:12 and the strobe-program count in bits 11:0; other bits read 0.
- R4: A write to program-data while idle and with unlock field 0x3E77 starts a program cycle. The cycle has relax+1 cycles, then strobe-program+1 cycles with fuseStrobe high, then relax+1 cycles.
- R5: A program cycle ORs the program-data word into fuse word bank*8+word, where the address is bank<<3 | word. When the cycle ends, the unlock field is cleared.
- R6: A write of 1 to read-control bit 0 while idle starts a sense cycle: relax+1 cycles, then strobe-read+1 strobe cycles, then relax+1 cycles. Afterwards read-data holds the addressed fuse word. A write with bit 0 at 0 has no effect.
- R7: A write to program-data while the unlock field is not 0x3E77 sets the error flag. No cycle starts, busy stays low and no fuse changes.
- R8: A program-data write, or a read-control write with bit 0 at 1, made while busy sets the error flag and is otherwise ignored. The running cycle completes unchanged.
- R9: The error flag is sticky. Only a write through the clear alias with bit 9 at 1 clears it.
- R10: Busy (control bit 8) is high for exactly the cycles of a running access, and fuseStrobe is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the register at regAddr (combinational) |
| fuseStrobe | output | 1 | High during the strobe phase of an access |

## Verification
The bench measures the three phases cycle by cycle, including the case where every count is zero. A sequencer that was off by one in any phase would report the wrong busy length or the wrong number of strobe cycles. A second program cycle to a word that already holds data checks that bits accumulate. A design that stored the new word instead of ORing it would lose the earlier bits. The bench also writes to a neighbouring bank and reads it back, which catches an address that does not split into bank and word as specified.

Refused accesses are tried both with the key missing and while busy, and a sense is repeated afterwards. A design that wrote the fuse anyway, started a cycle, or let the second request disturb the running one would return different read data or a different busy length. The error flag is checked across plain writes and a clear-alias write, and the unlock field is read back after a program cycle. A design that dropped the sticky error or kept the key would fail those reads.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;
  localparam int REG_AW   = 3;
  localparam int DATA_W   = 32;
  localparam int FADDR_W  = 7;
  localparam int WPB      = 8;
  localparam int CNT_W    = 12;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_SET   = 3'd1;
  localparam logic [REG_AW-1:0] RA_CLR   = 3'd2;
  localparam logic [REG_AW-1:0] RA_TIME  = 3'd3;
  localparam logic [REG_AW-1:0] RA_RCTL  = 3'd4;
  localparam logic [REG_AW-1:0] RA_RDATA = 3'd5;
  localparam logic [REG_AW-1:0] RA_PDATA = 3'd6;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  typedef struct packed {
    logic startProg;
    logic startSense;
    logic doProg;
    logic doSense;
    logic keyClear;
  } seqCmd_t;

  typedef enum logic [1:0] {PH_IDLE, PH_RELAX_A, PH_STROBE, PH_RELAX_B} seqPhase_e;
endpackage

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic                wdStart,
  input  logic                wdErrBit,
  input  logic                keyOk,
  input  logic [3:0]          relaxCnt,
  input  logic [5:0]          strobeReadCnt,
  input  logic [CNT_W-1:0]    strobeProgCnt,
  output seqCmd_t             cmd,
  output logic                busy,
  output logic                errFlag,
  output logic                fuseStrobe
);
  seqPhase_e         phase;
  logic [CNT_W-1:0]  cnt;
  logic              opIsProg;
  logic              progReq, senseReq, errSet, errClr, lastCycle;
  logic [CNT_W-1:0]  relaxLoad;

  assign progReq   = regWe && (regAddr == RA_PDATA);
  assign senseReq  = regWe && (regAddr == RA_RCTL) && wdStart;
  assign errClr    = regWe && (regAddr == RA_CLR) && wdErrBit;
  assign busy      = (phase != PH_IDLE);
  assign fuseStrobe = (phase == PH_STROBE);
  assign lastCycle = (cnt == '0);
  assign relaxLoad = {{(CNT_W-4){1'b0}}, relaxCnt};
  assign errSet    = (progReq && (busy || !keyOk)) || (senseReq && busy);

  always_comb begin
    cmd.startProg  = progReq && !busy && keyOk;
    cmd.startSense = senseReq && !busy;
    cmd.doProg     = (phase == PH_STROBE) && lastCycle && opIsProg;
    cmd.doSense    = (phase == PH_STROBE) && lastCycle && !opIsProg;
    cmd.keyClear   = (phase == PH_RELAX_B) && lastCycle && opIsProg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      opIsProg <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (cmd.startProg || cmd.startSense) begin
            phase    <= PH_RELAX_A;
            cnt      <= relaxLoad;
            opIsProg <= cmd.startProg;
          end
        end
        PH_RELAX_A: begin
          if (lastCycle) begin
            phase <= PH_STROBE;
            cnt   <= opIsProg ? strobeProgCnt : {{(CNT_W-6){1'b0}}, strobeReadCnt};
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (lastCycle) begin
            phase <= PH_RELAX_B;
            cnt   <= relaxLoad;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (lastCycle) phase <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        errFlag <= 1'b0;
    else if (errSet)  errFlag <= 1'b1;
    else if (errClr)  errFlag <= 1'b0;
  end
endmodule

// File: rtl/fuse_seq_dp.sv
module fuse_seq_dp
  import fuse_seq_pkg::*;
#(
  parameter int BANKS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  input  seqCmd_t             cmd,
  input  logic                busy,
  input  logic                errFlag,
  output logic [DATA_W-1:0]   regRdata,
  output logic [15:0]         ctrlKey,
  output logic [3:0]          relaxCnt,
  output logic [5:0]          strobeReadCnt,
  output logic [CNT_W-1:0]    strobeProgCnt
);
  localparam int NWORDS = BANKS * WPB;

  logic [FADDR_W-1:0] ctrlAddr, opAddr;
  logic [DATA_W-1:0]  readData, progData;
  logic [DATA_W-1:0]  fuseWord [NWORDS];
  logic [DATA_W-1:0]  senseWord;
  logic               opValid;

  assign opValid   = (32'(opAddr) < NWORDS);
  assign senseWord = opValid ? fuseWord[opAddr[$clog2(NWORDS)-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlKey  <= '0;
      ctrlAddr <= '0;
    end else begin
      if (regWe) begin
        unique case (regAddr)
          RA_CTRL: begin
            ctrlKey  <= regWdata[31:16];
            ctrlAddr <= regWdata[FADDR_W-1:0];
          end
          RA_SET: begin
            ctrlKey  <= ctrlKey | regWdata[31:16];
            ctrlAddr <= ctrlAddr | regWdata[FADDR_W-1:0];
          end
          RA_CLR: begin
            ctrlKey  <= ctrlKey & ~regWdata[31:16];
            ctrlAddr <= ctrlAddr & ~regWdata[FADDR_W-1:0];
          end
          default: ;
        endcase
      end
      if (cmd.keyClear) ctrlKey <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relaxCnt      <= '0;
      strobeReadCnt <= '0;
      strobeProgCnt <= '0;
    end else if (regWe && regAddr == RA_TIME) begin
      strobeReadCnt <= regWdata[21:16];
      relaxCnt      <= regWdata[15:12];
      strobeProgCnt <= regWdata[11:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr   <= '0;
      progData <= '0;
      readData <= '0;
    end else begin
      if (cmd.startProg) begin
        opAddr   <= ctrlAddr;
        progData <= regWdata;
      end
      if (cmd.startSense) opAddr <= ctrlAddr;
      if (cmd.doSense)    readData <= senseWord;
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN)
        fuseWord[g] <= '0;
      else if (cmd.doProg && opAddr == FADDR_W'(g))
        fuseWord[g] <= fuseWord[g] | progData;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      RA_CTRL, RA_SET, RA_CLR:
        regRdata = {ctrlKey, 6'b0, errFlag, busy, 1'b0, ctrlAddr};
      RA_TIME:  regRdata = {10'b0, strobeReadCnt, relaxCnt, strobeProgCnt};
      RA_RDATA: regRdata = readData;
      RA_PDATA: regRdata = progData;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/fuse_seq_top.sv
module fuse_seq_top
  import fuse_seq_pkg::*;
#(
  parameter int BANKS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic               fuseStrobe
);
  seqCmd_t          cmd;
  logic             busy, errFlag, keyOk;
  logic [15:0]      ctrlKey;
  logic [3:0]       relaxCnt;
  logic [5:0]       strobeReadCnt;
  logic [CNT_W-1:0] strobeProgCnt;

  assign keyOk = (ctrlKey == UNLOCK_KEY);

  fuse_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .wdStart(regWdata[0]), .wdErrBit(regWdata[9]), .keyOk(keyOk),
    .relaxCnt(relaxCnt), .strobeReadCnt(strobeReadCnt), .strobeProgCnt(strobeProgCnt),
    .cmd(cmd), .busy(busy), .errFlag(errFlag), .fuseStrobe(fuseStrobe)
  );

  fuse_seq_dp #(.BANKS(BANKS)) uDp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .cmd(cmd), .busy(busy), .errFlag(errFlag), .regRdata(regRdata),
    .ctrlKey(ctrlKey), .relaxCnt(relaxCnt), .strobeReadCnt(strobeReadCnt),
    .strobeProgCnt(strobeProgCnt)
  );
endmodule

// File: rtl/fuse_seq_chk.sv
module fuse_seq_chk
  import fuse_seq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [2:0]  regAddr,
  input logic [31:0] regWdata,
  input logic        fuseStrobe,
  input logic        busy,
  input logic        errFlag,
  input logic [15:0] ctrlKey
);
  AST_PROG_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == RA_PDATA && !busy && ctrlKey == UNLOCK_KEY |=> busy); // R4

  AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    fuseStrobe |-> busy); // R10

  AST_NOKEY_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == RA_PDATA && !busy && ctrlKey != UNLOCK_KEY |=> !busy && errFlag); // R7

  AST_BUSY_REQ_ERR: assert property (@(posedge clk) disable iff (!rstN)
    busy && regWe && (regAddr == RA_PDATA || (regAddr == RA_RCTL && regWdata[0])) |=> errFlag && busy); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !(regWe && regAddr == RA_CLR && regWdata[9]) |=> errFlag); // R9

  AST_SENSE_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == RA_RCTL && regWdata[0] && !busy |=> busy); // R6
endmodule

bind fuse_seq_top fuse_seq_chk uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .fuseStrobe(fuseStrobe), .busy(busy), .errFlag(errFlag), .ctrlKey(ctrlKey)
);

// File: tb/tb_fuse_seq_top.sv
`timescale 1ns/1ps
module tb_fuse_seq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        fuseStrobe;
  int          errors = 0;
  int          checks = 0;

  localparam logic [2:0] A_CTRL = 3'd0, A_SET = 3'd1, A_CLR = 3'd2, A_TIME = 3'd3,
                         A_RCTL = 3'd4, A_RDATA = 3'd5, A_PDATA = 3'd6;

  typedef struct packed {
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 32'hFFFF_FFFF, 3'd0, 32'hFFFF_007F},
    '{3'd2, 32'h0000_0070, 3'd0, 32'hFFFF_000F},
    '{3'd1, 32'h0001_0030, 3'd1, 32'hFFFF_003F},
    '{3'd2, 32'hFFFF_0000, 3'd2, 32'h0000_003F},
    '{3'd0, 32'h1234_0300, 3'd0, 32'h1234_0000},
    '{3'd3, 32'hFFFF_FFFF, 3'd3, 32'h003F_FFFF},
    '{3'd3, 32'h0003_2005, 3'd3, 32'h0003_2005},
    '{3'd4, 32'h0000_0000, 3'd0, 32'h1234_0000}
  };

  fuse_seq_top dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .fuseStrobe(fuseStrobe)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic runWait(output int nBusy, output int nPre, output int nStr);
    logic [31:0] d;
    nBusy = 0; nPre = 0; nStr = 0;
    for (int k = 0; k < 4000; k++) begin
      regAddr = A_CTRL;
      #1;
      d = regRdata;
      if (!d[8]) break;
      nBusy++;
      if (fuseStrobe) nStr++;
      else if (nStr == 0) nPre++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired got=%h exp=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int nb, np, ns;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
    rd(A_TIME, d);  chk("R1 timing", d, 32'h0);
    rd(A_RDATA, d); chk("R1 rdata", d, 32'h0);
    rd(A_PDATA, d); chk("R1 pdata", d, 32'h0);
    chk("R1 strobe", {31'b0, fuseStrobe}, 32'h0);

    // vector table: aliases and timing fields (R2, R3, R6)
    for (int i = 0; i < 8; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, d);
      chk(i < 5 ? "R2 vector" : (i < 7 ? "R3 vector" : "R6 vector"), d, VECS[i].ex);
    end

    // R4 R5 R10 program with relax=2, sprog=5
    wr(A_CTRL, {16'h3E77, 9'b0, 7'h1D});
    wr(A_PDATA, 32'h0000_00F0);
    runWait(nb, np, ns);
    chk("R10 program busy length", nb, 32'd12);
    chk("R4 pre-strobe relax", np, 32'd3);
    chk("R4 strobe length", ns, 32'd6);
    rd(A_CTRL, d); chk("R5 key cleared", d, 32'h0000_001D);

    // R6 sense, sread=3
    wr(A_RCTL, 32'h1);
    runWait(nb, np, ns);
    chk("R6 sense busy length", nb, 32'd10);
    chk("R6 sense strobe", ns, 32'd4);
    rd(A_RDATA, d); chk("R6 sensed data", d, 32'h0000_00F0);

    // R5 accumulate by OR
    wr(A_SET, 32'h3E77_0000);
    wr(A_PDATA, 32'h0F00_000F);
    runWait(nb, np, ns);
    wr(A_RCTL, 32'h1);
    runWait(nb, np, ns);
    rd(A_RDATA, d); chk("R5 OR accumulate", d, 32'h0F00_00FF);

    // R5 bank/word mapping
    wr(A_CTRL, {16'h3E77, 9'b0, 7'h01});
    wr(A_PDATA, 32'hA5A5_0001);
    runWait(nb, np, ns);
    wr(A_CTRL, 32'h0000_0008);
    wr(A_RCTL, 32'h1);
    runWait(nb, np, ns);
    rd(A_RDATA, d); chk("R5 neighbour bank untouched", d, 32'h0);
    wr(A_CTRL, 32'h0000_0001);
    wr(A_RCTL, 32'h1);
    runWait(nb, np, ns);
    rd(A_RDATA, d); chk("R5 bank0 word1", d, 32'hA5A5_0001);

    // R7 program without key
    wr(A_PDATA, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R7 error set, not busy", d, 32'h0000_0201);
    wr(A_RCTL, 32'h1);
    runWait(nb, np, ns);
    rd(A_RDATA, d); chk("R7 fuse unchanged", d, 32'hA5A5_0001);

    // R9 sticky error
    wr(A_CTRL, 32'h0000_0001);
    rd(A_CTRL, d); chk("R9 plain write keeps error", d, 32'h0000_0201);
    wr(A_SET, 32'h0000_0000);
    wr(A_CLR, 32'h0000_0200);
    rd(A_CTRL, d); chk("R9 clear alias clears error", d, 32'h0000_0001);

    // R8 sense request while busy
    wr(A_CTRL, {16'h3E77, 9'b0, 7'h1D});
    wr(A_RCTL, 32'h1);
    wr(A_RCTL, 32'h1);
    runWait(nb, np, ns);
    chk("R8 running sense completes", nb, 32'd8);
    rd(A_CTRL, d); chk("R8 error and key kept", d, 32'h3E77_021D);
    rd(A_RDATA, d); chk("R8 sense data", d, 32'h0F00_00FF);

    // R8 program request while busy
    wr(A_CLR, 32'h0000_0200);
    wr(A_RCTL, 32'h1);
    wr(A_PDATA, 32'hFFFF_FFFF);
    runWait(nb, np, ns);
    rd(A_CTRL, d); chk("R8 program during busy flags", d, 32'h3E77_021D);
    wr(A_RCTL, 32'h1);
    runWait(nb, np, ns);
    rd(A_RDATA, d); chk("R8 fuse unchanged", d, 32'h0F00_00FF);

    // R4 R6 boundary: all counts zero
    wr(A_TIME, 32'h0);
    wr(A_CTRL, {16'h3E77, 9'b0, 7'h20});
    wr(A_PDATA, 32'h0000_0001);
    runWait(nb, np, ns);
    chk("R4 zero-count busy", nb, 32'd3);
    chk("R4 zero-count pre", np, 32'd1);
    chk("R4 zero-count strobe", ns, 32'd1);
    wr(A_RCTL, 32'h1);
    runWait(nb, np, ns);
    chk("R6 zero-count sense busy", nb, 32'd3);
    rd(A_RDATA, d); chk("R6 zero-count data", d, 32'h0000_0001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule